// File: doc/BRIEF.md
# Memory Access Trace Port

This block sits beside an on-chip memory bus and watches it without ever driving it. Accesses that pass a master filter and land inside one of two address windows are captured in the same cycle and queued in a small FIFO. A packetiser then sends each queued item over a narrow synchronous output made of a clock, a frame sync and a parallel data bus. This lets an external capture device rebuild the memory contents.

In trace mode, a packet carries a header beat (direction, master, window index), then the address, then the data. In direct data mode, only the data word is sent. That word comes either from a CPU write on a dedicated data port or from a traced read. The output clock is divided down from the system clock. It either runs all the time or stays low whenever nothing is being sent.

Top module: `mem_trace_port`

## Requirements
- R1: While rst_ni is low, tclk_o, tsync_o, tdata_o and ovf_o are all 0.
- R2: A trace-mode packet is 9 beats of 4 bits, sent most-significant first and sampled on rising tclk_o:
  - Beat 1 is the header: bit 3 = write (1) or read (0), bit 2 = master (1 = DMA, 0 = CPU), bit 1 = window index, bit 0 = 0.
  - The next 4 beats carry the address, then 4 beats carry the data.
  - The data is bus_wdata_i for writes and bus_rdata_i for reads.
  - tsync_o is high for every beat of a packet and drops after the last one.
- R3: Window n is selected by reg_lo_i/reg_hi_i slice n (bits [16n+15:16n]). It matches when lo <= address <= hi and the enable bit n for that direction (reg_wr_en_i or reg_rd_en_i) is set. When both windows match, the packet reports window 0. Accesses that match no window produce no packet.
- R4: An access is captured only if its master is enabled: cpu_en_i for master 0, dma_en_i for master 1.
- R5: Captured accesses on back-to-back cycles are absorbed. The FIFO holds 4 entries while one more packet is being sent, and packets leave in capture order.
- R6: A capture that finds the FIFO full is dropped and sets ovf_o. ovf_o stays set until a cycle with ovf_clr_i high, and a new drop in that same cycle keeps it set.
- R7: With mode_i = 1 (direct), two things produce a 4-beat packet with only the data word and no header or address:
  - a dir_wr_i pulse, which queues dir_data_i;
  - a filtered read, which queues bus_rdata_i.
  Writes on the bus are not captured in this mode.
- R8: In direct mode, if dir_wr_i coincides with a filtered read, the dir_data_i word is queued, the read is dropped and ovf_o is set.
- R9: With mode_i = 0 (trace), dir_wr_i has no effect: no packet is sent.
- R10: While it runs, tclk_o has a period of 2*(prescale_i+1) system clock cycles, and so never less than 2.
- R11: With free_run_i = 1, tclk_o toggles even when idle. With free_run_i = 0, tclk_o stays low whenever no packet is in flight.
- R12: tdata_o and tsync_o change only in a cycle where tclk_o is low, that is at a falling edge of tclk_o or while it is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = trace, 1 = direct data |
| cpu_en_i | input | 1 | Capture CPU accesses |
| dma_en_i | input | 1 | Capture DMA accesses |
| free_run_i | input | 1 | 1 = output clock always runs |
| prescale_i | input | 4 | Output clock half period minus one, in system cycles |
| reg_lo_i | input | 32 | Window lower bounds, window n in bits [16n+15:16n] |
| reg_hi_i | input | 32 | Window upper bounds, inclusive |
| reg_rd_en_i | input | 2 | Per-window read capture enable |
| reg_wr_en_i | input | 2 | Per-window write capture enable |
| bus_valid_i | input | 1 | Monitored bus access in this cycle |
| bus_we_i | input | 1 | Access is a write |
| bus_mst_i | input | 1 | Master of the access, 0 = CPU, 1 = DMA |
| bus_addr_i | input | 16 | Access address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_i | input | 16 | Read data, valid with bus_valid_i |
| dir_wr_i | input | 1 | CPU direct data write strobe |
| dir_data_i | input | 16 | CPU direct data word |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| ovf_o | output | 1 | Sticky capture-dropped flag |
| tclk_o | output | 1 | Trace output clock |
| tsync_o | output | 1 | Frame sync, high during a packet |
| tdata_o | output | 4 | Trace output data |

## Verification
The assertions assume that each bus access is complete in a single cycle, with its read data present in the same cycle as bus_valid_i. They also assume that the window, mode and clock settings do not move while a packet is partly sent, because a change of prescale_i mid-phase only shortens or stretches the current phase. The stimulus changes configuration only after the output has drained and tclk_o is low. It holds every bus access for exactly one cycle, except in the overflow burst, which deliberately issues eight consecutive captured writes.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
  typedef enum logic {MODE_TRACE = 1'b0, MODE_DIRECT = 1'b1} mtp_mode_e;
  typedef enum logic {MST_CPU = 1'b0, MST_DMA = 1'b1} mtp_mst_e;
  // header bits ahead of the window index: write flag, master
  localparam int HDR_FIXED = 2;
endpackage

// File: rtl/mtp_filter.sv
module mtp_filter
  import mtp_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int NREG = 2,
  localparam int RIW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int EW  = 1 + HDR_FIXED + RIW + AW + DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             cpu_en_i,
  input  logic             dma_en_i,
  input  logic [NREG*AW-1:0] reg_lo_i,
  input  logic [NREG*AW-1:0] reg_hi_i,
  input  logic [NREG-1:0]  reg_rd_en_i,
  input  logic [NREG-1:0]  reg_wr_en_i,
  input  logic             bus_valid_i,
  input  logic             bus_we_i,
  input  logic             bus_mst_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  input  logic [DW-1:0]    bus_rdata_i,
  input  logic             dir_wr_i,
  input  logic [DW-1:0]    dir_data_i,
  output logic             push_o,
  output logic             collide_o,
  output logic [EW-1:0]    entry_o
);
  logic [NREG-1:0] hit;
  logic [RIW-1:0]  ridx;
  logic            mst_ok, trace_hit, rd_hit;

  for (genvar g = 0; g < NREG; g++) begin : g_win
    logic [AW-1:0] lo, hi;
    assign lo = reg_lo_i[g*AW +: AW];
    assign hi = reg_hi_i[g*AW +: AW];
    assign hit[g] = (bus_addr_i >= lo) && (bus_addr_i <= hi) &&
                    (bus_we_i ? reg_wr_en_i[g] : reg_rd_en_i[g]);
  end

  // lowest window index wins
  always_comb begin
    ridx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (hit[i]) ridx = i[RIW-1:0];
  end

  assign mst_ok    = (bus_mst_i == MST_DMA) ? dma_en_i : cpu_en_i;
  assign trace_hit = bus_valid_i && mst_ok && (|hit);
  assign rd_hit    = trace_hit && !bus_we_i;

  always_comb begin
    push_o    = 1'b0;
    collide_o = 1'b0;
    entry_o   = {1'b0, bus_we_i, bus_mst_i, ridx, bus_addr_i,
                 bus_we_i ? bus_wdata_i : bus_rdata_i};
    if (mode_i == MODE_TRACE) begin
      push_o = trace_hit;
    end else if (dir_wr_i) begin
      push_o    = 1'b1;
      collide_o = rd_hit;
      entry_o   = {1'b1, 1'b1, 1'b0, {RIW{1'b0}}, {AW{1'b0}}, dir_data_i};
    end else if (rd_hit) begin
      push_o  = 1'b1;
      entry_o = {1'b1, 1'b0, bus_mst_i, ridx, bus_addr_i, bus_rdata_i};
    end
  end

  // R9: strobe without a bus access never captures in trace mode
  assert_dir_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_TRACE && !bus_valid_i) |-> !push_o);
  // R4: a disabled master never produces a capture in trace mode
  assert_master_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_TRACE && bus_mst_i && !dma_en_i) |-> !push_o);
endmodule

// File: rtl/mtp_fifo.sv
module mtp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PTW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0]   mem [DEPTH];
  logic [PTW-1:0] wp_q, rp_q;
  logic [CW-1:0]  cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign rdata_o = mem[rp_q];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_i) wp_q <= (wp_q == PTW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (rd_i) rp_q <= (rp_q == PTW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      if (wr_i && !rd_i)      cnt_q <= cnt_q + 1'b1;
      else if (rd_i && !wr_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> (cnt_q < CW'(DEPTH)));
  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> (cnt_q != '0));
endmodule

// File: rtl/mtp_serializer.sv
module mtp_serializer
  import mtp_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int OW    = 4,
  parameter int RIW   = 1,
  parameter int PRE_W = 4,
  localparam int EW     = 1 + HDR_FIXED + RIW + AW + DW,
  localparam int PW     = OW + AW + DW,
  localparam int TBEATS = 1 + AW / OW + DW / OW,
  localparam int DBEATS = DW / OW,
  localparam int BW     = $clog2(TBEATS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EW-1:0]    entry_i,
  input  logic             avail_i,
  input  logic             free_run_i,
  input  logic [PRE_W-1:0] prescale_i,
  output logic             pop_o,
  output logic             tclk_o,
  output logic             tsync_o,
  output logic [OW-1:0]    tdata_o
);
  logic             kind, we, mst;
  logic [RIW-1:0]   ridx;
  logic [AW-1:0]    addr;
  logic [DW-1:0]    data;
  logic [OW-1:0]    hdr;
  logic [PW-1:0]    pkt, sh_q;
  logic [BW-1:0]    beats_q;
  logic [PRE_W-1:0] cnt_q;
  logic             tclk_q, busy_q, tsync_q;
  logic             running, tick, fall, load;

  assign kind = entry_i[EW-1];
  assign we   = entry_i[EW-2];
  assign mst  = entry_i[EW-3];
  assign ridx = entry_i[EW-4 -: RIW];
  assign addr = entry_i[DW +: AW];
  assign data = entry_i[DW-1:0];

  always_comb begin
    hdr = '0;
    hdr[OW-1] = we;
    hdr[OW-2] = mst;
    hdr[OW-3 -: RIW] = ridx;
  end

  assign pkt = kind ? {data, {(PW-DW){1'b0}}} : {hdr, addr, data};

  assign running = free_run_i || busy_q || tclk_q;
  assign tick    = running && (cnt_q >= prescale_i);
  assign fall    = tick && tclk_q;
  // start only at a falling edge, or at once while the stopped clock is low
  assign load    = !busy_q && avail_i && (fall || (!free_run_i && !tclk_q));
  assign pop_o   = load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tclk_q <= 1'b0;
    end else begin
      if (!running || load || tick) cnt_q <= '0;
      else                          cnt_q <= cnt_q + 1'b1;
      if (tick) tclk_q <= ~tclk_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      tsync_q <= 1'b0;
      sh_q    <= '0;
      beats_q <= '0;
    end else if (load) begin
      busy_q  <= 1'b1;
      tsync_q <= 1'b1;
      sh_q    <= pkt;
      beats_q <= kind ? BW'(DBEATS) : BW'(TBEATS);
    end else if (busy_q && fall) begin
      if (beats_q == BW'(1)) begin
        busy_q  <= 1'b0;
        tsync_q <= 1'b0;
        sh_q    <= '0;
        beats_q <= '0;
      end else begin
        sh_q    <= sh_q << OW;
        beats_q <= beats_q - 1'b1;
      end
    end
  end

  assign tclk_o  = tclk_q;
  assign tsync_o = tsync_q;
  assign tdata_o = sh_q[PW-1 -: OW];

  assert_edge_align_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(tsync_o) || !$stable(tdata_o)) |-> !tclk_o);
  assert_stop_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!free_run_i && !busy_q && !tclk_q) |=> !tclk_o);
  assert_sync_framing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tsync_o) |-> $fell(tclk_o));
endmodule

// File: rtl/mem_trace_port.sv
module mem_trace_port
  import mtp_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int OW    = 4,
  parameter int NREG  = 2,
  parameter int DEPTH = 4,
  parameter int PRE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_i,
  input  logic               cpu_en_i,
  input  logic               dma_en_i,
  input  logic               free_run_i,
  input  logic [PRE_W-1:0]   prescale_i,
  input  logic [NREG*AW-1:0] reg_lo_i,
  input  logic [NREG*AW-1:0] reg_hi_i,
  input  logic [NREG-1:0]    reg_rd_en_i,
  input  logic [NREG-1:0]    reg_wr_en_i,
  input  logic               bus_valid_i,
  input  logic               bus_we_i,
  input  logic               bus_mst_i,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic [DW-1:0]      bus_wdata_i,
  input  logic [DW-1:0]      bus_rdata_i,
  input  logic               dir_wr_i,
  input  logic [DW-1:0]      dir_data_i,
  input  logic               ovf_clr_i,
  output logic               ovf_o,
  output logic               tclk_o,
  output logic               tsync_o,
  output logic [OW-1:0]      tdata_o
);
  localparam int RIW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int EW  = 1 + HDR_FIXED + RIW + AW + DW;

  logic          push, collide, full, empty, pop, drop, ovf_q;
  logic [EW-1:0] cap_entry, head_entry;

  mtp_filter #(.AW(AW), .DW(DW), .NREG(NREG)) u_filter (
    .clk_i, .rst_ni, .mode_i, .cpu_en_i, .dma_en_i,
    .reg_lo_i, .reg_hi_i, .reg_rd_en_i, .reg_wr_en_i,
    .bus_valid_i, .bus_we_i, .bus_mst_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_i,
    .dir_wr_i, .dir_data_i,
    .push_o(push), .collide_o(collide), .entry_o(cap_entry)
  );

  assign drop = push && full;

  mtp_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .wr_i(push && !full), .wdata_i(cap_entry),
    .rd_i(pop), .rdata_o(head_entry),
    .empty_o(empty), .full_o(full)
  );

  mtp_serializer #(.AW(AW), .DW(DW), .OW(OW), .RIW(RIW), .PRE_W(PRE_W)) u_ser (
    .clk_i, .rst_ni,
    .entry_i(head_entry), .avail_i(!empty),
    .free_run_i, .prescale_i,
    .pop_o(pop), .tclk_o, .tsync_o, .tdata_o
  );

  // set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ovf_q <= 1'b0;
    else if (drop || collide)  ovf_q <= 1'b1;
    else if (ovf_clr_i)        ovf_q <= 1'b0;
  end
  assign ovf_o = ovf_q;

  assert_ovf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
  assert_drop_flags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && full) |=> ovf_o);
  assert_collide_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collide |=> ovf_o);
endmodule

// File: tb/sim_mem_trace_port.sv
module sim_mem_trace_port;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        mode, cpu_en, dma_en, free_run;
  logic [3:0]  prescale;
  logic [31:0] reg_lo, reg_hi;
  logic [1:0]  rd_en, wr_en;
  logic        valid, we, mst, dir_wr, ovf_clr;
  logic [15:0] addr, wdata, rdata, dir_data;
  logic        ovf, tclk, tsync;
  logic [3:0]  tdata;

  always #4 clk = ~clk;

  mem_trace_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .cpu_en_i(cpu_en), .dma_en_i(dma_en),
    .free_run_i(free_run), .prescale_i(prescale), .reg_lo_i(reg_lo), .reg_hi_i(reg_hi),
    .reg_rd_en_i(rd_en), .reg_wr_en_i(wr_en), .bus_valid_i(valid), .bus_we_i(we),
    .bus_mst_i(mst), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_i(rdata),
    .dir_wr_i(dir_wr), .dir_data_i(dir_data), .ovf_clr_i(ovf_clr), .ovf_o(ovf),
    .tclk_o(tclk), .tsync_o(tsync), .tdata_o(tdata)
  );

  int ntot = 0, nfail = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    ntot++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // receiver: sample on rising tclk while sync high, close frame on falling sync
  logic [35:0] acc = '0, fval[64];
  int          nb = 0, nfr = 0, fbeats[64], edge_bad = 0;

  always @(posedge tclk) if (tsync) begin acc = {acc[31:0], tdata}; nb++; end
  always @(negedge tsync) if (nb > 0 && nfr < 64) begin
    fval[nfr] = acc; fbeats[nfr] = nb; nfr++; acc = '0; nb = 0;
  end
  always @(tdata or tsync) begin
    #1;
    if (rst_n && tclk) edge_bad++;
  end

  initial begin
    #(8 * 150000);
    nfail++; ntot++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic access(input logic w, input logic m, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    valid = 1'b1; we = w; mst = m; addr = a; wdata = d; rdata = d;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic dwrite(input logic [15:0] d);
    @(negedge clk);
    dir_wr = 1'b1; dir_data = d;
    @(negedge clk);
    dir_wr = 1'b0;
  endtask

  typedef struct packed {
    logic we; logic mst; logic [15:0] a; logic [15:0] d; logic hit; logic ridx;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b1, 1'b0, 16'h1000, 16'hA5A5, 1'b1, 1'b0},  // lower bound
    '{1'b0, 1'b1, 16'h10FF, 16'h3C3C, 1'b1, 1'b0},  // upper bound, DMA read
    '{1'b1, 1'b0, 16'h1100, 16'h1111, 1'b0, 1'b0},  // just above
    '{1'b0, 1'b0, 16'h2010, 16'h2222, 1'b0, 1'b0},  // window 1 read disabled
    '{1'b1, 1'b1, 16'h20FF, 16'h5A5A, 1'b1, 1'b1},  // window 1 write
    '{1'b1, 1'b0, 16'h0FFF, 16'h3333, 1'b0, 1'b0},  // just below
    '{1'b0, 1'b0, 16'h1080, 16'hC0DE, 1'b1, 1'b0}   // CPU read
  };

  initial begin
    int b;
    time t1, t2;
    mode = 1'b0; cpu_en = 1'b1; dma_en = 1'b1; free_run = 1'b0; prescale = 4'd0;
    reg_lo = {16'h2000, 16'h1000}; reg_hi = {16'h20FF, 16'h10FF};
    rd_en = 2'b01; wr_en = 2'b11;
    valid = 1'b0; we = 1'b0; mst = 1'b0; addr = '0; wdata = '0; rdata = '0;
    dir_wr = 1'b0; dir_data = '0; ovf_clr = 1'b0;
    idle(3);
    chk("R1 reset outputs", {ovf, tclk, tsync, tdata}, 7'd0);
    rst_n = 1'b1;
    idle(3);

    for (int i = 0; i < 7; i++) begin
      b = nfr;
      access(VECS[i].we, VECS[i].mst, VECS[i].a, VECS[i].d);
      idle(40);
      if (VECS[i].hit) begin
        chk("R3 window hit frame count", nfr, b + 1);
        chk("R2 trace packet", fval[b],
            {VECS[i].we, VECS[i].mst, VECS[i].ridx, 1'b0, VECS[i].a, VECS[i].d});
        chk("R2 trace beat count", fbeats[b], 9);
      end else begin
        chk("R3 window miss frame count", nfr, b);
      end
    end

    // R4 master filter
    dma_en = 1'b0; b = nfr;
    access(1'b1, 1'b1, 16'h1010, 16'h7E7E);
    idle(40);
    chk("R4 disabled DMA not captured", nfr, b);
    access(1'b1, 1'b0, 16'h1010, 16'h7E7E);
    idle(40);
    chk("R4 enabled CPU captured", nfr, b + 1);
    dma_en = 1'b1;

    // R3 overlap: window 0 wins
    reg_lo = {16'h1000, 16'h1000}; reg_hi = {16'h10FF, 16'h10FF}; b = nfr;
    access(1'b1, 1'b0, 16'h1050, 16'h0F0F);
    idle(40);
    chk("R3 overlap reports window 0", fval[b], {4'b1000, 16'h1050, 16'h0F0F});
    reg_lo = {16'h2000, 16'h1000}; reg_hi = {16'h20FF, 16'h10FF};

    // R5/R6 burst of 8 consecutive captures
    b = nfr;
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      valid = 1'b1; we = 1'b1; mst = 1'b0; addr = 16'h1000 + 16'(k); wdata = 16'(k);
      @(negedge clk);
    end
    valid = 1'b0;
    idle(200);
    chk("R5 burst frames kept", nfr, b + 5);
    chk("R5 first burst frame order", fval[b][15:0], 16'd0);
    chk("R5 last burst frame order", fval[b+4][15:0], 16'd4);
    chk("R6 overflow flag sticky", ovf, 1'b1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    chk("R6 overflow cleared", ovf, 1'b0);

    // R9 trace mode ignores strobe
    b = nfr;
    dwrite(16'h4444);
    idle(40);
    chk("R9 strobe ignored in trace", nfr, b);

    // R7 direct mode
    mode = 1'b1; b = nfr;
    dwrite(16'hBEEF);
    idle(40);
    chk("R7 direct frame count", nfr, b + 1);
    chk("R7 direct word", fval[b][15:0], 16'hBEEF);
    chk("R7 direct beat count", fbeats[b], 4);
    access(1'b0, 1'b0, 16'h1020, 16'h1234);
    idle(40);
    chk("R7 traced read pushed", fval[b+1][15:0], 16'h1234);
    access(1'b1, 1'b0, 16'h1020, 16'h9999);
    idle(40);
    chk("R7 write not captured in direct", nfr, b + 2);

    // R8 collision
    b = nfr;
    @(negedge clk);
    dir_wr = 1'b1; dir_data = 16'h5555;
    valid = 1'b1; we = 1'b0; mst = 1'b0; addr = 16'h1030; rdata = 16'h7777;
    @(negedge clk);
    dir_wr = 1'b0; valid = 1'b0;
    idle(40);
    chk("R8 collision single frame", nfr, b + 1);
    chk("R8 strobe word wins", fval[b][15:0], 16'h5555);
    chk("R8 collision flags overflow", ovf, 1'b1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;

    // R11 stopped clock while idle
    b = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (tclk) b++; end
    chk("R11 clock held low when idle", b, 0);

    // R10 / R11 free-running clock with prescale 2
    prescale = 4'd2; free_run = 1'b1;
    @(posedge tclk); t1 = $time;
    @(posedge tclk); t2 = $time;
    chk("R10 output clock period", 64'(t2 - t1), 64'd48);
    b = nfr;
    dwrite(16'hA1B2);
    idle(100);
    chk("R11 free-run frame", fval[b][15:0], 16'hA1B2);
    chk("R12 outputs change only with clock low", edge_bad, 0);

    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end
endmodule